// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs a source-side base address, a memory-side base address, an item count and a control word through a small register write port. The channel then moves items one at a time. Each item is read from the source port and then written to the destination port, over two simple single-beat request/acknowledge master ports: a peripheral-side port and a memory-side port. A level-sensitive peripheral request paces the items. In memory-to-memory mode the channel runs free as soon as it is enabled.

Both address pointers step by the access width of their own side when stepping is enabled for that side. In circular mode the count and both pointers reload at the end of every pass, and the channel keeps running until software clears the enable. Three sticky event flags (full pass done, half pass done, bus error) feed one interrupt line through per-event enables. A 2-bit priority is stored and presented for an external arbiter.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset the enable output, all flags, the interrupt and both port requests are 0.
- R2: Register offsets are 0 control, 1 peripheral base, 2 memory base, 3 count, 4 flag clear. While the channel is enabled, writes to offsets 1 to 3 are ignored, and a control write changes only the enable bit (bit 0). All other control fields, including the priority shown on `prio`, keep their values.
- R3: Control bit 1 selects the direction: 0 reads the peripheral port and writes the memory port, 1 does the reverse. Each item is one read beat followed by one write beat that carries the read data. A request stays high until it is acknowledged.
- R4: Control bit 4 (peripheral) and bit 5 (memory) enable address stepping. Bits [7:6] (peripheral) and [9:8] (memory) give the width: 0 = 8, 1 = 16, 2 = 32 bits (3 acts as 32). They are also driven on that side's size output. A stepping pointer advances by 1, 2 or 4 after each item. A non-stepping pointer stays fixed.
- R5: With control bit 3 (memory-to-memory) set, items run back to back from the enable write without any peripheral request, until the count is exhausted.
- R6: Without circular mode, the channel issues no request once the remaining count reaches 0, even with a peripheral request present. An enable with a programmed count of 0 moves nothing.
- R7: With control bit 2 (circular) set, when the remaining count reaches 0 it reloads from the programmed count, both pointers reload from their bases, and the channel keeps serving requests.
- R8: Flag bit 0 (full) sets when the remaining count reaches 0, on every pass. Flag bit 1 (half) sets when the remaining count becomes the programmed count shifted right by one.
- R9: An error response on either port sets flag bit 2, clears the enable, and stops the transfer.
- R10: Flags stay set until a write to offset 4 with a 1 in the matching bit. `irq` is high when any flag is set whose enable is set: control bit 12 for full, 13 for half, 14 for error.
- R11: The pointers and the remaining count load from the base and count registers on each enable write (bit 0 written as 1 while disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| dreq | input | 1 | Peripheral transfer request (level) |
| p_req | output | 1 | Peripheral port request |
| p_we | output | 1 | Peripheral port write (1) or read (0) |
| p_addr | output | AW | Peripheral port address |
| p_size | output | 2 | Peripheral access width code |
| p_wdata | output | DW | Peripheral port write data |
| p_rdata | input | DW | Peripheral port read data |
| p_ack | input | 1 | Peripheral port acknowledge |
| p_err | input | 1 | Peripheral port error, valid with ack |
| m_req | output | 1 | Memory port request |
| m_we | output | 1 | Memory port write (1) or read (0) |
| m_addr | output | AW | Memory port address |
| m_size | output | 2 | Memory access width code |
| m_wdata | output | DW | Memory port write data |
| m_rdata | input | DW | Memory port read data |
| m_ack | input | 1 | Memory port acknowledge |
| m_err | input | 1 | Memory port error, valid with ack |
| chan_en | output | 1 | Channel enable state |
| flags | output | 3 | {error, half, full} sticky flags |
| irq | output | 1 | Channel interrupt |
| prio | output | 2 | Stored priority for an external arbiter |

## Verification
The bench aims at the end of a pass. A design that forgets to stop would issue an extra write on a late request, and one that forgets to reload in circular mode would keep stepping past the buffer instead of returning to the base address. It programs a zero count and rewrites the configuration while the channel is enabled. A careless design would either launch bogus transfers or let a half-finished buffer jump to a new address and count. Errors are injected on a write beat and on a read beat, so a channel that keeps going after an error shows up as extra logged beats and an enable still set. Mixed widths per side show whether each pointer steps by its own width rather than by the other side's.

// File: rtl/dmx_pkg.sv
// Shared types and register offsets for the DMA channel.
package dmx_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xsize_e;

    typedef enum logic [2:0] {
        OFS_CTRL  = 3'd0,
        OFS_PBASE = 3'd1,
        OFS_MBASE = 3'd2,
        OFS_COUNT = 3'd3,
        OFS_CLEAR = 3'd4
    } reg_ofs_e;

    typedef struct packed {
        logic       ie_err;
        logic       ie_half;
        logic       ie_full;
        logic [1:0] prio;
        xsize_e     mw;
        xsize_e     pw;
        logic       minc;
        logic       pinc;
        logic       m2m;
        logic       circ;
        logic       dir;
    } ctrl_t;

    // Flag bit positions
    localparam int FL_FULL = 0;
    localparam int FL_HALF = 1;
    localparam int FL_ERR  = 2;
endpackage

// File: rtl/dmx_regs.sv
// Configuration registers, enable bit and sticky event flags.
// Assumes events from the sequencer are single-cycle pulses.
// Configuration is frozen while enabled; the flag clear is always honoured.
module dmx_regs
    import dmx_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          full_evt,
    input  logic          half_evt,
    input  logic          err_evt,
    output ctrl_t         ctrl,
    output logic [AW-1:0] pbase,
    output logic [AW-1:0] mbase,
    output logic [CW-1:0] total,
    output logic          en,
    output logic          start,
    output logic [2:0]    flags,
    output logic          irq
);
    logic   ctrl_wr, clr_wr;
    logic [2:0] set_mask, clr_mask, sticky;
    ctrl_t  ctrl_new;

    // Decode the write strobes for the control and flag-clear offsets.
    assign ctrl_wr  = cfg_we && (cfg_addr == OFS_CTRL);
    assign clr_wr   = cfg_we && (cfg_addr == OFS_CLEAR);
    assign start    = ctrl_wr && !en && cfg_wdata[0] && !err_evt;
    assign set_mask = {err_evt, half_evt, full_evt};
    assign clr_mask = clr_wr ? cfg_wdata[2:0] : 3'b000;
    assign sticky   = flags & ~clr_mask;

    // Unpack the control word from the write data.
    always_comb begin
        ctrl_new.dir     = cfg_wdata[1];
        ctrl_new.circ    = cfg_wdata[2];
        ctrl_new.m2m     = cfg_wdata[3];
        ctrl_new.pinc    = cfg_wdata[4];
        ctrl_new.minc    = cfg_wdata[5];
        ctrl_new.pw      = xsize_e'(cfg_wdata[7:6]);
        ctrl_new.mw      = xsize_e'(cfg_wdata[9:8]);
        ctrl_new.prio    = cfg_wdata[11:10];
        ctrl_new.ie_full = cfg_wdata[12];
        ctrl_new.ie_half = cfg_wdata[13];
        ctrl_new.ie_err  = cfg_wdata[14];
    end

    // Configuration registers: writable only while the channel is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            pbase <= '0;
            mbase <= '0;
            total <= '0;
        end else if (cfg_we && !en) begin
            case (cfg_addr)
                OFS_CTRL:  ctrl  <= ctrl_new;
                OFS_PBASE: pbase <= cfg_wdata[AW-1:0];
                OFS_MBASE: mbase <= cfg_wdata[AW-1:0];
                OFS_COUNT: total <= cfg_wdata[CW-1:0];
                default:   ;
            endcase
        end
    end

    // Enable bit: a bus error clears it, otherwise the control write sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        en <= 1'b0;
        else if (err_evt)  en <= 1'b0;
        else if (ctrl_wr)  en <= cfg_wdata[0];
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= sticky | set_mask;
    end

    // Interrupt line from the enabled flags.
    assign irq = |(flags & {ctrl.ie_err, ctrl.ie_half, ctrl.ie_full});

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(total) && $stable(pbase) && $stable(mbase) && $stable(ctrl)));
    p_err_disables_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> !en);
    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & $past(sticky)) == $past(sticky)));
endmodule

// File: rtl/dmx_ptr.sv
// One address pointer. It loads from its base and steps by the access width.
// Assumes load has priority over step in the same cycle.
module dmx_ptr
    import dmx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          inc,
    input  xsize_e        width,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = AW'(1);
    logic [AW-1:0] stride;

    // Stride in bytes for the selected width; the spare code acts as a word.
    always_comb begin
        case (width)
            SZ_BYTE: stride = ONE;
            SZ_HALF: stride = ONE << 1;
            default: stride = ONE << 2;
        endcase
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)          addr <= '0;
        else if (load)       addr <= base;
        else if (step && inc) addr <= addr + stride;
    end

    p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !inc) |=> $stable(addr));
endmodule

// File: rtl/dmx_seq.sv
// Item sequencer: read beat on the source port, then write beat on the
// destination port. It counts the remaining items and raises the events.
// Assumes ack and err are single-cycle responses to a held request.
module dmx_seq
    import dmx_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic          en,
    input  logic          start,
    input  logic [CW-1:0] total,
    input  logic          dreq,
    output logic          p_req,
    output logic          p_we,
    input  logic [DW-1:0] p_rdata,
    input  logic          p_ack,
    input  logic          p_err,
    output logic          m_req,
    output logic          m_we,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ack,
    input  logic          m_err,
    output logic [DW-1:0] wdata,
    output logic          step,
    output logic          reload,
    output logic          full_evt,
    output logic          half_evt,
    output logic          err_evt
);
    typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_e;
    st_e           state;
    logic [CW-1:0] rem, rem_dec;
    logic          src_ack, src_err, dst_ack, dst_err, go, done, last;
    logic [DW-1:0] src_data;

    // Route the handshake of each side according to the direction bit.
    assign src_ack  = ctrl.dir ? m_ack : p_ack;
    assign src_err  = ctrl.dir ? m_err : p_err;
    assign src_data = ctrl.dir ? m_rdata : p_rdata;
    assign dst_ack  = ctrl.dir ? p_ack : m_ack;
    assign dst_err  = ctrl.dir ? p_err : m_err;

    // Bus requests: one side reads in S_RD, the other side writes in S_WR.
    assign p_req = ctrl.dir ? (state == S_WR) : (state == S_RD);
    assign m_req = ctrl.dir ? (state == S_RD) : (state == S_WR);
    assign p_we  = ctrl.dir;
    assign m_we  = !ctrl.dir;

    // Item completion and events.
    assign go       = en && (rem != '0) && (ctrl.m2m || dreq);
    assign done     = (state == S_WR) && dst_ack && !dst_err;
    assign rem_dec  = rem - 1'b1;
    assign last     = done && (rem_dec == '0);
    assign step     = done;
    assign reload   = start || (last && ctrl.circ);
    assign full_evt = last;
    assign half_evt = done && (rem_dec == (total >> 1));
    assign err_evt  = ((state == S_RD) && src_ack && src_err) ||
                      ((state == S_WR) && dst_ack && dst_err);

    // Beat state machine and captured data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            wdata <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) state <= S_RD;
                S_RD: if (src_ack) begin
                    state <= src_err ? S_IDLE : S_WR;
                    wdata <= src_data;
                end
                S_WR: if (dst_ack) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Remaining item count: load on enable, step per item, reload in circular mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      rem <= '0;
        else if (start)  rem <= total;
        else if (done)   rem <= (last && ctrl.circ) ? total : rem_dec;
    end

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && !p_ack) |=> p_req);
    m_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> m_req);
    p_stop_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rem == '0) && (state == S_IDLE)) |=> !(p_req || m_req));
endmodule

// File: rtl/dma_xfer_channel.sv
// Top of the single DMA channel: registers, sequencer and two pointers.
// Assumes AW <= 32 so a base address fits one register write.
module dma_xfer_channel
    import dmx_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          dreq,
    output logic          p_req,
    output logic          p_we,
    output logic [AW-1:0] p_addr,
    output logic [1:0]    p_size,
    output logic [DW-1:0] p_wdata,
    input  logic [DW-1:0] p_rdata,
    input  logic          p_ack,
    input  logic          p_err,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ack,
    input  logic          m_err,
    output logic          chan_en,
    output logic [2:0]    flags,
    output logic          irq,
    output logic [1:0]    prio
);
    localparam int NSIDE = 2;   // index 0: peripheral side, 1: memory side

    ctrl_t         ctrl;
    logic [AW-1:0] pbase, mbase;
    logic [CW-1:0] total;
    logic          start, step, reload, full_evt, half_evt, err_evt;
    logic [DW-1:0] wdata;
    logic [AW-1:0] base_v [NSIDE];
    logic [AW-1:0] addr_v [NSIDE];
    logic          inc_v  [NSIDE];
    xsize_e        wid_v  [NSIDE];

    dmx_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .full_evt(full_evt), .half_evt(half_evt),
        .err_evt(err_evt), .ctrl(ctrl), .pbase(pbase), .mbase(mbase),
        .total(total), .en(chan_en), .start(start), .flags(flags), .irq(irq)
    );

    dmx_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .en(chan_en), .start(start),
        .total(total), .dreq(dreq),
        .p_req(p_req), .p_we(p_we), .p_rdata(p_rdata), .p_ack(p_ack), .p_err(p_err),
        .m_req(m_req), .m_we(m_we), .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err),
        .wdata(wdata), .step(step), .reload(reload),
        .full_evt(full_evt), .half_evt(half_evt), .err_evt(err_evt)
    );

    // Per-side pointer configuration.
    assign base_v[0] = pbase;
    assign base_v[1] = mbase;
    assign inc_v[0]  = ctrl.pinc;
    assign inc_v[1]  = ctrl.minc;
    assign wid_v[0]  = ctrl.pw;
    assign wid_v[1]  = ctrl.mw;

    // One pointer per side.
    for (genvar s = 0; s < NSIDE; s++) begin : g_ptr
        dmx_ptr #(.AW(AW)) u_ptr (
            .clk(clk), .rst_n(rst_n), .load(reload), .step(step),
            .inc(inc_v[s]), .width(wid_v[s]), .base(base_v[s]), .addr(addr_v[s])
        );
    end

    assign p_addr  = addr_v[0];
    assign m_addr  = addr_v[1];
    assign p_size  = ctrl.pw;
    assign m_size  = ctrl.mw;
    assign p_wdata = wdata;
    assign m_wdata = wdata;
    assign prio    = ctrl.prio;
endmodule

// File: tb/dma_xfer_channel_test.sv
// Directed bench for the DMA channel; each task checks its own scenario.
module dma_xfer_channel_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic dreq = 1'b0;
    logic p_req, p_we, m_req, m_we, chan_en, irq;
    logic [AW-1:0] p_addr, m_addr;
    logic [1:0] p_size, m_size, prio;
    logic [DW-1:0] p_wdata, m_wdata;
    logic [DW-1:0] p_rdata = '0, m_rdata = '0;
    logic p_ack = 1'b0, p_err = 1'b0, m_ack = 1'b0, m_err = 1'b0;
    logic [2:0] flags;

    int n_checks = 0;
    int n_err = 0;

    // Bus model controls and logs
    logic log_clr = 1'b0;
    logic p_inj = 1'b0, m_inj = 1'b0;
    logic [AW-1:0] p_err_addr = '0, m_err_addr = '0;
    logic [31:0] pw_addr [64];
    logic [31:0] pw_dat  [64];
    logic [1:0]  pw_sz   [64];
    logic [31:0] mw_addr [64];
    logic [31:0] mw_dat  [64];
    logic [1:0]  mw_sz   [64];
    logic [31:0] pr_addr [64];
    int pw_n = 0, mw_n = 0, pr_n = 0, mr_n = 0;

    dma_xfer_channel #(.AW(AW), .DW(DW), .CW(16)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dreq(dreq),
        .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_size(p_size),
        .p_wdata(p_wdata), .p_rdata(p_rdata), .p_ack(p_ack), .p_err(p_err),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err),
        .chan_en(chan_en), .flags(flags), .irq(irq), .prio(prio)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    // Peripheral-side slave: ack one cycle after a request, log every beat.
    always @(posedge clk) begin
        if (!rst_n || log_clr) begin
            p_ack <= 1'b0; p_err <= 1'b0; pw_n <= 0; pr_n <= 0;
        end else begin
            p_ack   <= p_req && !p_ack;
            p_err   <= p_req && !p_ack && p_inj && (p_addr == p_err_addr);
            p_rdata <= 32'hA500_0000 ^ p_addr;
            if (p_req && !p_ack) begin
                if (p_we) begin
                    pw_addr[pw_n[5:0]] <= p_addr;
                    pw_dat[pw_n[5:0]]  <= p_wdata;
                    pw_sz[pw_n[5:0]]   <= p_size;
                    pw_n <= pw_n + 1;
                end else begin
                    pr_addr[pr_n[5:0]] <= p_addr;
                    pr_n <= pr_n + 1;
                end
            end
        end
    end

    // Memory-side slave: same protocol with its own data pattern.
    always @(posedge clk) begin
        if (!rst_n || log_clr) begin
            m_ack <= 1'b0; m_err <= 1'b0; mw_n <= 0; mr_n <= 0;
        end else begin
            m_ack   <= m_req && !m_ack;
            m_err   <= m_req && !m_ack && m_inj && (m_addr == m_err_addr);
            m_rdata <= 32'hB600_0000 ^ m_addr;
            if (m_req && !m_ack) begin
                if (m_we) begin
                    mw_addr[mw_n[5:0]] <= m_addr;
                    mw_dat[mw_n[5:0]]  <= m_wdata;
                    mw_sz[mw_n[5:0]]   <= m_size;
                    mw_n <= mw_n + 1;
                end else begin
                    mr_n <= mr_n + 1;
                end
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        dreq = 1'b0;
        cycles(10);
    endtask

    task automatic clear_logs();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    function automatic logic [31:0] mk(input bit en, input bit dir, input bit circ,
                                       input bit m2m, input bit pinc, input bit minc,
                                       input logic [1:0] pw, input logic [1:0] mw,
                                       input logic [1:0] pr, input logic [2:0] ie);
        return {17'd0, ie, pr, mw, pw, minc, pinc, m2m, circ, dir, en};
    endfunction

    // Disable, clear all flags and empty the logs.
    task automatic quiesce();
        wr(3'd0, 32'd0);
        wr(3'd4, 32'h7);
        clear_logs();
    endtask

    task automatic t_reset();
        check("R1 enable after reset", {31'd0, chan_en}, 0);
        check("R1 flags after reset", {29'd0, flags}, 0);
        check("R1 irq after reset", {31'd0, irq}, 0);
        check("R1 requests after reset", {30'd0, p_req, m_req}, 0);
    endtask

    // Peripheral to memory, paced by requests, fixed source, 16-bit stepping destination.
    task automatic t_p2m();
        quiesce();
        wr(3'd1, 32'h40);
        wr(3'd2, 32'h10);
        wr(3'd3, 32'd3);
        wr(3'd0, mk(1, 0, 0, 0, 0, 1, 2'd2, 2'd1, 2'd0, 3'b001));
        cycles(5);
        check("R3 no beat without request", pr_n + mw_n, 0);
        pulse_req();
        pulse_req();
        check("R8 half flag after 2 of 3", {29'd0, flags}, 3'b010);
        check("R10 irq masked for half", {31'd0, irq}, 0);
        pulse_req();
        check("R3 read beats", pr_n, 3);
        check("R4 fixed source address", pr_addr[2], 32'h40);
        check("R4 dest addr 0", mw_addr[0], 32'h10);
        check("R4 dest addr 1 step 2", mw_addr[1], 32'h12);
        check("R4 dest addr 2 step 2", mw_addr[2], 32'h14);
        check("R3 data passed through", mw_dat[1], 32'hA500_0040);
        check("R4 dest size code", {30'd0, mw_sz[2]}, 1);
        check("R8 full and half set", {29'd0, flags}, 3'b011);
        check("R10 irq from full", {31'd0, irq}, 1);
        pulse_req();
        check("R6 no beat after count exhausted", mw_n, 3);
        wr(3'd4, 32'h1);
        check("R10 w1c clears only full", {29'd0, flags}, 3'b010);
        check("R10 irq drops", {31'd0, irq}, 0);
    endtask

    // Memory to peripheral in free-running mode with 8-bit peripheral stepping.
    task automatic t_m2m();
        quiesce();
        wr(3'd1, 32'h20);
        wr(3'd2, 32'h80);
        wr(3'd3, 32'd4);
        wr(3'd0, mk(1, 1, 0, 1, 1, 1, 2'd0, 2'd2, 2'd0, 3'b000));
        cycles(40);
        check("R5 writes without request", pw_n, 4);
        check("R5 memory reads", mr_n, 4);
        check("R4 periph addr 3 step 1", pw_addr[3], 32'h23);
        check("R3 data item 0", pw_dat[0], 32'hB600_0080);
        check("R4 data item 3 from word step", pw_dat[3], 32'hB600_008C);
        check("R4 periph size code", {30'd0, pw_sz[1]}, 0);
        check("R8 flags after m2m", {29'd0, flags}, 3'b011);
        check("R10 irq all masked", {31'd0, irq}, 0);
    endtask

    task automatic t_zero_count();
        quiesce();
        wr(3'd3, 32'd0);
        wr(3'd0, mk(1, 0, 0, 1, 1, 1, 2'd2, 2'd2, 2'd0, 3'b111));
        cycles(20);
        check("R6 zero count moves nothing", pr_n + mr_n + pw_n + mw_n, 0);
        check("R6 zero count no flags", {29'd0, flags}, 0);
    endtask

    // Circular pass reload, then configuration writes while enabled.
    task automatic t_circ_and_freeze();
        quiesce();
        wr(3'd1, 32'h44);
        wr(3'd2, 32'h30);
        wr(3'd3, 32'd2);
        wr(3'd0, mk(1, 0, 1, 0, 0, 1, 2'd2, 2'd0, 2'd1, 3'b010));
        pulse_req();
        pulse_req();
        check("R7 pass 1 addr 1", mw_addr[1], 32'h31);
        check("R8 flags pass 1", {29'd0, flags}, 3'b011);
        check("R10 irq from half", {31'd0, irq}, 1);
        wr(3'd4, 32'h3);
        check("R10 flags cleared", {29'd0, flags}, 0);
        pulse_req();
        pulse_req();
        check("R7 pointer reloaded", mw_addr[2], 32'h30);
        check("R7 pass 2 addr 1", mw_addr[3], 32'h31);
        check("R7 full flag again", {29'd0, flags}, 3'b011);
        check("R7 still enabled", {31'd0, chan_en}, 1);
        // R2: config writes while enabled
        wr(3'd0, mk(1, 0, 0, 0, 0, 1, 2'd2, 2'd0, 2'd3, 3'b000));
        wr(3'd2, 32'h70);
        wr(3'd3, 32'd5);
        check("R2 priority unchanged", {30'd0, prio}, 1);
        check("R2 enable kept", {31'd0, chan_en}, 1);
        pulse_req();
        check("R2 base unchanged", mw_addr[4], 32'h30);
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd3, 3'b000));
        check("R2 enable bit clears", {31'd0, chan_en}, 0);
        pulse_req();
        check("R2 no beat when disabled", mw_n, 5);
        wr(3'd0, mk(0, 0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd3, 3'b000));
        check("R2 fields writable when disabled", {30'd0, prio}, 3);
    endtask

    // Re-enable reloads pointers and count from the registers.
    task automatic t_reenable();
        quiesce();
        wr(3'd1, 32'h08);
        wr(3'd2, 32'h90);
        wr(3'd3, 32'd1);
        wr(3'd0, mk(1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 2'd0, 3'b000));
        pulse_req();
        wr(3'd0, 32'd0);
        wr(3'd0, mk(1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 2'd0, 3'b000));
        pulse_req();
        check("R11 second run restarts at base", mw_addr[1], 32'h90);
        check("R11 source restarts at base", pr_addr[1], 32'h08);
    endtask

    task automatic t_errors();
        quiesce();
        wr(3'd1, 32'h00);
        wr(3'd2, 32'h50);
        wr(3'd3, 32'd4);
        m_err_addr = 32'h54; m_inj = 1'b1;
        wr(3'd0, mk(1, 0, 0, 1, 1, 1, 2'd2, 2'd2, 2'd0, 3'b100));
        cycles(40);
        check("R9 stops after write error", mw_n, 2);
        check("R9 no further reads", pr_n, 2);
        check("R9 error flag only", {29'd0, flags}, 3'b100);
        check("R9 enable cleared", {31'd0, chan_en}, 0);
        check("R10 irq from error", {31'd0, irq}, 1);
        m_inj = 1'b0;
        quiesce();
        wr(3'd1, 32'h60);
        wr(3'd3, 32'd3);
        p_err_addr = 32'h60; p_inj = 1'b1;
        wr(3'd0, mk(1, 0, 0, 0, 0, 1, 2'd2, 2'd2, 2'd0, 3'b000));
        pulse_req();
        check("R9 read error no write", mw_n, 0);
        check("R9 read error flag", {29'd0, flags}, 3'b100);
        check("R9 read error disables", {31'd0, chan_en}, 0);
        p_inj = 1'b0;
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_p2m();
        t_m2m();
        t_zero_count();
        t_circ_and_freeze();
        t_reenable();
        t_errors();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        cycles(20000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule